// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block watches a two-wire I2C bus without ever driving it. A fast system clock samples the clock line and the data line. The block finds the bus conditions: a first START, a repeated START and a STOP. It shifts in each address and data byte and records the acknowledge bit that follows each byte. Every item it decodes appears as a one-cycle event on a small output port. The port carries a 4-bit type code and a payload byte.

The address byte is reported with its direction bit removed, and that bit sets the direction of the event. Data bytes that follow inherit the direction of the most recent address. Between a START and the STOP that ends the transfer, the block counts the sampled bits and the system clocks. When the STOP arrives it presents both counts, so that software or a bench can work out the bitrate as bits divided by the elapsed time.

Top module: `i2c_passive_monitor`

## Requirements
- R1: A falling data line while the clock line is high, seen when the bus is idle, produces an event with type 0 (first START) and payload 0.
- R2: The first byte after any START is sampled on eight clock-line rising edges, most significant bit first. If its bit 0 is 1 it produces type 6 (address read), and if bit 0 is 0 it produces type 7 (address write). The payload is the byte shifted right by one, so 0xA2 is reported as 0x51.
- R3: The clock-line rising edge after each byte samples the acknowledge bit. A low data line gives type 3 (ACK) and a high data line gives type 4 (NACK). The payload is 0.
- R4: Bytes after an acknowledge are data bytes. They produce type 8 (data read) if the last address was a read and type 9 (data write) if it was a write, with the whole byte as payload.
- R5: A START seen after an earlier START and before any STOP produces type 1 (repeated START). The next byte after it is decoded as an address again.
- R6: A rising data line while the clock line is high, seen in the data phase, produces type 2 (STOP) with payload 0 and returns the block to idle. The next START is then reported as type 0 again.
- R7: During the address byte and the acknowledge bit, data-line changes while the clock line is high are ignored. They produce no condition event and leave the sampled byte unchanged.
- R8: While the bus is idle, clock-line edges produce no event.
- R9: In the same cycle as a STOP event, xfer_done pulses for one cycle. xfer_bits then equals the number of clock-line rising edges counted in the address and data phases since the latest START, and xfer_cycles equals the STOP detection cycle minus the START detection cycle, plus one.
- R10: The elapsed-cycle count saturates at 2^CYC_CNT_W-1 and does not wrap.
- R11: After a synchronous active-high reset, evt_valid and xfer_done are 0, and xfer_bits and xfer_cycles are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Observed bus clock line (asynchronous) |
| sda_in | input | 1 | Observed bus data line (asynchronous) |
| evt_valid | output | 1 | One-cycle pulse marking a decoded event |
| evt_type | output | 4 | Event code: 0 START, 1 repeated START, 2 STOP, 3 ACK, 4 NACK, 6/7 address read/write, 8/9 data read/write |
| evt_data | output | 8 | Shifted address, data byte, or 0 |
| xfer_done | output | 1 | Pulse alongside a STOP event |
| xfer_bits | output | BIT_CNT_W | Bits counted since the latest START |
| xfer_cycles | output | CYC_CNT_W | Clocks from START detection to STOP detection, inclusive |

## Verification
A wrong phase state shows up at the event port within one byte. A lost repeated-start flag changes type 1 into type 0 at the very next START. A stale direction turns a data-read into a data-write on the next data byte. An off-by-one bit index shifts every later payload and moves the acknowledge event by one bit time. That in turn makes the next condition look like data. Counter faults appear only at STOP, as a wrong xfer_bits or xfer_cycles. A missing saturation appears as a small wrapped value after a transfer that is held open for a long time.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  typedef enum logic [3:0] {
    EV_START   = 4'd0,
    EV_RESTART = 4'd1,
    EV_STOP    = 4'd2,
    EV_ACK     = 4'd3,
    EV_NACK    = 4'd4,
    EV_ADDR_RD = 4'd6,
    EV_ADDR_WR = 4'd7,
    EV_DATA_RD = 4'd8,
    EV_DATA_WR = 4'd9
  } evt_code_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_ACK  = 2'd2,
    PH_DATA = 2'd3
  } phase_t;

  // Append one sampled bit below the bits already collected (MSB first on the wire).
  function automatic logic [7:0] shift_in(input logic [7:0] acc, input logic bit_v);
    return {acc[6:0], bit_v};
  endfunction

  // Address as reported: direction bit dropped.
  function automatic logic [7:0] addr_field(input logic [7:0] b);
    return {1'b0, b[7:1]};
  endfunction

  // Event code for a completed byte.
  function automatic evt_code_t byte_code(input logic is_addr, input logic rd);
    if (is_addr) return rd ? EV_ADDR_RD : EV_ADDR_WR;
    return rd ? EV_DATA_RD : EV_DATA_WR;
  endfunction

  function automatic evt_code_t ack_code(input logic sda_level);
    return sda_level ? EV_NACK : EV_ACK;
  endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic start_seen,
  output logic stop_seen
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_prev, sda_prev;
  logic scl_cur, sda_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_in;
      sda_pipe[0] <= sda_in;
      for (int i = 1; i < STAGES; i++) begin
        scl_pipe[i] <= scl_pipe[i-1];
        sda_pipe[i] <= sda_pipe[i-1];
      end
      scl_prev <= scl_cur;
      sda_prev <= sda_cur;
    end
  end

  assign scl_cur    = scl_pipe[STAGES-1];
  assign sda_cur    = sda_pipe[STAGES-1];
  assign sda_lvl    = sda_cur;
  assign scl_rise   = scl_cur & ~scl_prev;
  // Conditions need the clock line high in both samples, so they never coincide with a rise.
  assign start_seen = scl_prev & scl_cur & sda_prev & ~sda_cur;
  assign stop_seen  = scl_prev & scl_cur & ~sda_prev & sda_cur;

endmodule

// File: rtl/i2cmon_decoder.sv
module i2cmon_decoder
  import i2cmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sda_lvl,
  input  logic      scl_rise,
  input  logic      start_seen,
  input  logic      stop_seen,
  output logic      start_ok,
  output logic      stop_ok,
  output logic      bit_taken,
  output logic      evt_valid,
  output evt_code_t evt_type,
  output logic [7:0] evt_data
);
  phase_t     phase_q;
  logic [7:0] acc_q;
  logic [2:0] idx_q;
  logic       rd_q;
  logic       rep_q;
  logic [7:0] acc_nxt;
  logic       ack_taken;

  assign start_ok  = start_seen && (phase_q == PH_IDLE || phase_q == PH_DATA);
  assign stop_ok   = stop_seen && (phase_q == PH_DATA);
  assign bit_taken = scl_rise && (phase_q == PH_ADDR || phase_q == PH_DATA);
  assign ack_taken = scl_rise && (phase_q == PH_ACK);
  assign acc_nxt   = shift_in(acc_q, sda_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      acc_q     <= '0;
      idx_q     <= '0;
      rd_q      <= 1'b0;
      rep_q     <= 1'b0;
      evt_valid <= 1'b0;
      evt_type  <= EV_START;
      evt_data  <= '0;
    end else begin
      evt_valid <= 1'b0;
      if (start_ok) begin
        evt_valid <= 1'b1;
        evt_type  <= rep_q ? EV_RESTART : EV_START;
        evt_data  <= '0;
        rep_q     <= 1'b1;
        phase_q   <= PH_ADDR;
        acc_q     <= '0;
        idx_q     <= '0;
      end else if (stop_ok) begin
        evt_valid <= 1'b1;
        evt_type  <= EV_STOP;
        evt_data  <= '0;
        rep_q     <= 1'b0;
        rd_q      <= 1'b0;
        phase_q   <= PH_IDLE;
        acc_q     <= '0;
        idx_q     <= '0;
      end else if (bit_taken) begin
        if (idx_q == 3'd7) begin
          evt_valid <= 1'b1;
          if (phase_q == PH_ADDR) begin
            rd_q     <= acc_nxt[0];
            evt_type <= byte_code(1'b1, acc_nxt[0]);
            evt_data <= addr_field(acc_nxt);
          end else begin
            evt_type <= byte_code(1'b0, rd_q);
            evt_data <= acc_nxt;
          end
          phase_q <= PH_ACK;
          acc_q   <= '0;
          idx_q   <= '0;
        end else begin
          acc_q <= acc_nxt;
          idx_q <= idx_q + 3'd1;
        end
      end else if (ack_taken) begin
        evt_valid <= 1'b1;
        evt_type  <= ack_code(sda_lvl);
        evt_data  <= '0;
        phase_q   <= PH_DATA;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE && !start_seen) |=> !evt_valid); // R8

  AST_COND_PAYLOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_type inside {EV_START, EV_RESTART, EV_STOP, EV_ACK, EV_NACK}) |-> (evt_data == 8'd0)); // R1

  AST_BYTE_THEN_ACK: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_type inside {EV_ADDR_RD, EV_ADDR_WR, EV_DATA_RD, EV_DATA_WR}) |-> (phase_q == PH_ACK)); // R3

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> (phase_q == PH_ADDR && evt_valid)); // R5

  AST_ADDR_IGNORES_COND: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_ADDR || phase_q == PH_ACK) && (start_seen || stop_seen)) |=> !(evt_valid && evt_type inside {EV_START, EV_RESTART, EV_STOP})); // R7

endmodule

// File: rtl/i2cmon_meter.sv
module i2cmon_meter #(
  parameter int BIT_CNT_W = 16,
  parameter int CYC_CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_ok,
  input  logic                 stop_ok,
  input  logic                 bit_taken,
  output logic                 xfer_done,
  output logic [BIT_CNT_W-1:0] xfer_bits,
  output logic [CYC_CNT_W-1:0] xfer_cycles
);
  localparam logic [CYC_CNT_W-1:0] CYC_MAX = '1;

  logic [BIT_CNT_W-1:0] bits_q;
  logic [CYC_CNT_W-1:0] cyc_q;
  logic                 active_q;

  function automatic logic [BIT_CNT_W-1:0] bits_inc(input logic [BIT_CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  function automatic logic [CYC_CNT_W-1:0] cyc_inc(input logic [CYC_CNT_W-1:0] v);
    return (v == CYC_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q      <= '0;
      cyc_q       <= '0;
      active_q    <= 1'b0;
      xfer_done   <= 1'b0;
      xfer_bits   <= '0;
      xfer_cycles <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (start_ok) begin
        bits_q   <= '0;
        cyc_q    <= {{(CYC_CNT_W-1){1'b0}}, 1'b1};
        active_q <= 1'b1;
      end else if (stop_ok) begin
        xfer_done   <= 1'b1;
        xfer_bits   <= bits_q;
        xfer_cycles <= cyc_inc(cyc_q);
        active_q    <= 1'b0;
      end else if (active_q) begin
        cyc_q <= cyc_inc(cyc_q);
        if (bit_taken) bits_q <= bits_inc(bits_q);
      end
    end
  end

  AST_CYC_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (active_q && cyc_q == CYC_MAX && !start_ok) |=> (cyc_q == CYC_MAX)); // R10

  AST_BITS_CLEAR_AT_START: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> (bits_q == '0)); // R9

endmodule

// File: rtl/i2c_passive_monitor.sv
module i2c_passive_monitor
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BIT_CNT_W   = 16,
  parameter int CYC_CNT_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 evt_valid,
  output logic [3:0]           evt_type,
  output logic [7:0]           evt_data,
  output logic                 xfer_done,
  output logic [BIT_CNT_W-1:0] xfer_bits,
  output logic [CYC_CNT_W-1:0] xfer_cycles
);
  logic      sda_lvl, scl_rise, start_seen, stop_seen;
  logic      start_ok, stop_ok, bit_taken;
  evt_code_t evt_code;

  i2cmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .start_seen(start_seen), .stop_seen(stop_seen)
  );

  i2cmon_decoder u_dec (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .start_seen(start_seen), .stop_seen(stop_seen),
    .start_ok(start_ok), .stop_ok(stop_ok), .bit_taken(bit_taken),
    .evt_valid(evt_valid), .evt_type(evt_code), .evt_data(evt_data)
  );

  i2cmon_meter #(.BIT_CNT_W(BIT_CNT_W), .CYC_CNT_W(CYC_CNT_W)) u_meter (
    .clk(clk), .rst(rst), .start_ok(start_ok), .stop_ok(stop_ok),
    .bit_taken(bit_taken), .xfer_done(xfer_done),
    .xfer_bits(xfer_bits), .xfer_cycles(xfer_cycles)
  );

  assign evt_type = evt_code;

  AST_DONE_WITH_STOP: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (evt_valid && evt_type == 4'd2)); // R9

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!evt_valid && !xfer_done)); // R11

endmodule

// File: tb/i2c_passive_monitor_tb.sv
module i2c_passive_monitor_tb;
  localparam int Q      = 4;
  localparam int CYC_W  = 12;
  localparam int CYC_MX = (1 << CYC_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic              evt_valid;
  logic [3:0]        evt_type;
  logic [7:0]        evt_data;
  logic              xfer_done;
  logic [15:0]       xfer_bits;
  logic [CYC_W-1:0]  xfer_cycles;

  always #10 clk = ~clk;

  i2c_passive_monitor #(.SYNC_STAGES(2), .BIT_CNT_W(16), .CYC_CNT_W(CYC_W)) u_dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
    .evt_valid(evt_valid), .evt_type(evt_type), .evt_data(evt_data),
    .xfer_done(xfer_done), .xfer_bits(xfer_bits), .xfer_cycles(xfer_cycles)
  );

  typedef struct { int t; int d; string tag; } exp_evt_t;
  typedef struct { int bits; int cyc; } exp_xfer_t;
  exp_evt_t  evq[$];
  exp_xfer_t xq[$];

  int checks = 0;
  int errors = 0;
  longint cyc_now = 0;
  longint t_start = 0;
  int bits_exp = 0;
  bit dir_rd = 0;

  always @(posedge clk) cyc_now <= cyc_now + 1;

  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_evt(input int t, input int d, input string tag);
    exp_evt_t e;
    e.t = t; e.d = d; e.tag = tag;
    evq.push_back(e);
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops and compares as results appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (evt_valid) begin
        if (evq.size() == 0) begin
          check("unexpected event (R7 or R8)", 1'b0, evt_type, -1);
        end else begin
          exp_evt_t e;
          e = evq.pop_front();
          check({e.tag, " type"}, evt_type == e.t[3:0], evt_type, e.t);
          check({e.tag, " data"}, evt_data == e.d[7:0], evt_data, e.d);
        end
      end
      if (xfer_done) begin
        if (xq.size() == 0) begin
          check("unexpected xfer_done R9", 1'b0, 1, 0);
        end else begin
          exp_xfer_t x;
          x = xq.pop_front();
          check("R9 xfer_bits", xfer_bits == x.bits[15:0], xfer_bits, x.bits);
          check("R9/R10 xfer_cycles", xfer_cycles == x.cyc[CYC_W-1:0], xfer_cycles, x.cyc);
        end
      end
    end
  end

  // Clock line high, data line falls. Entry: both lines high.
  task automatic do_start(input bit rep);
    push_evt(rep ? 1 : 0, 0, rep ? "R5 repeated START" : "R1/R6 START");
    sda = 1'b0; t_start = cyc_now; bits_exp = 0;
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  // Entry: clock line low. The rise here is counted as a data-phase bit.
  task automatic do_restart();
    sda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    do_start(1'b1);
  endtask

  task automatic do_stop();
    longint d;
    exp_xfer_t x;
    push_evt(2, 0, "R6 STOP");
    sda = 1'b0; wq(Q); scl = 1'b1; wq(Q);
    bits_exp++;
    sda = 1'b1; d = cyc_now - t_start + 1;
    x.bits = bits_exp;
    x.cyc = (d > CYC_MX) ? CYC_MX : int'(d);
    xq.push_back(x);
    wq(Q);
  endtask

  // One bit; glitch toggles the data line while the clock line is high.
  task automatic do_bit(input bit v, input bit glitch);
    sda = v; wq(Q); scl = 1'b1;
    if (glitch && v) begin
      wq(2); sda = 1'b0; wq(3); sda = 1'b1; wq(3);
    end else begin
      wq(2*Q);
    end
    scl = 1'b0; wq(Q);
  endtask

  task automatic do_byte(input logic [7:0] b, input bit is_addr, input int glitch_pos);
    if (is_addr) begin
      dir_rd = b[0];
      push_evt(b[0] ? 6 : 7, {1'b0, b[7:1]}, b[0] ? "R2 addr read" : "R2 addr write");
    end else begin
      push_evt(dir_rd ? 8 : 9, b, dir_rd ? "R4 data read" : "R4 data write");
    end
    for (int i = 7; i >= 0; i--) do_bit(b[i], i == glitch_pos);
    bits_exp += 8;
  endtask

  task automatic do_ack(input bit nack);
    push_evt(nack ? 4 : 3, 0, nack ? "R3 NACK" : "R3 ACK");
    do_bit(nack, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    check("watchdog", 1'b0, 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wq(5);
    check("R11 evt_valid", evt_valid == 1'b0, evt_valid, 0);
    check("R11 xfer_done", xfer_done == 1'b0, xfer_done, 0);
    check("R11 xfer_bits", xfer_bits == 16'd0, xfer_bits, 0);
    check("R11 xfer_cycles", xfer_cycles == '0, xfer_cycles, 0);
    rst = 1'b0;
    wq(6);

    // R8: clock-line activity on an idle bus.
    for (int i = 0; i < 4; i++) begin scl = 1'b0; wq(Q); scl = 1'b1; wq(Q); end
    wq(10);

    // Write transfer.
    do_start(1'b0);
    do_byte(8'hA2, 1'b1, -1); do_ack(1'b0);
    do_byte(8'h3C, 1'b0, -1); do_ack(1'b0);
    do_byte(8'hFF, 1'b0, -1); do_ack(1'b1);
    do_stop();
    wq(20);

    // Read, then repeated START into a write.
    do_start(1'b0);
    do_byte(8'hA3, 1'b1, -1); do_ack(1'b0);
    do_byte(8'h5A, 1'b0, -1); do_ack(1'b1);
    do_restart();
    do_byte(8'h40, 1'b1, -1); do_ack(1'b0);
    do_byte(8'h81, 1'b0, -1); do_ack(1'b0);
    do_stop();
    wq(20);

    // R7: condition-like glitch inside the address byte.
    do_start(1'b0);
    do_byte(8'h6B, 1'b1, 3); do_ack(1'b0);
    do_byte(8'h00, 1'b0, -1); do_ack(1'b1);
    do_stop();
    wq(20);

    // R10: transfer held open beyond the counter range.
    do_start(1'b0);
    do_byte(8'h10, 1'b1, -1); do_ack(1'b0);
    wq(5000);
    do_stop();
    wq(20);

    check("R7/R8 no pending events", evq.size() == 0, evq.size(), 0);
    check("R9 no pending transfers", xq.size() == 0, xq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule